// File: doc/BRIEF.md
# Column Alignment and Outlier-Rejecting Averager

This block sits behind the per-detector correction stage of a scanning detector array that has five columns. The five columns cross the same scene point one scan period apart. Each corrected sample arrives on a serial stream, tagged with its column and its row.

The block delays each column by a different number of scan periods, so that the five looks at one scene point meet at the same time. It takes the median of those five values. Any value that lies above the median by more than a programmable rejection constant is treated as a radiation hit and dropped. The remaining values are averaged, with rounding to nearest.

Each row keeps its own delay history, so rows are handled independently. One averaged result leaves the block for every row group, in the same row order as the input.

Top module: `colavg_top`

## Requirements
- R1: While `rstN` is low and after its release, `outValid`, `outRow`, `outAvg` and `outCount` are zero, and every stored delay value is zero.
- R2: A sample with `inValid` high and `inCol` = 4 closes its row group. `outValid` is high for exactly the following cycle, and `outRow` then equals that sample's `inRow`.
- R3: At the close of a row group, the aligned value for column c (c = 0..4) is the column-c sample of the same row taken 4 − c scan periods earlier. Column 4 uses the current sample.
- R4: An aligned value is rejected when it is greater than median + `rejectK`, compared without overflow. `outCount` is the number of aligned values kept.
- R5: The median itself is never rejected, so `outCount` always lies between 1 and 5.
- R6: `outAvg` equals floor((2·S + n) / (2·n)), where S is the sum of the kept values and n is `outCount`. This is the mean rounded to nearest, with exact halves rounded up.
- R7: `rejectK` is read at the cycle that closes a row group. A new value takes effect from the next group.
- R8: A cycle with `inValid` low, or with `inCol` from 5 to 7, changes no stored value and produces no output.
- R9: Until a row has seen 4 − c earlier scans, the aligned value for column c of that row reads as zero.
- R10: Within a row group, columns 0 to 3 may arrive in any order. Each must arrive before column 4 of the same row, and groups of different rows must not interleave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inCol | input | 3 | Column tag of the sample (0 to 4) |
| inRow | input | RW = log2(ROWS) | Row of the sample |
| inData | input | W | Corrected sample value |
| rejectK | input | W | Rejection constant, above the median |
| outValid | output | 1 | Result strobe |
| outRow | output | RW | Row of the result |
| outAvg | output | W | Rounded mean of the kept values |
| outCount | output | 3 | Number of kept values |

## Verification
The hardest situation to reach is a full aligned set in which the values from different scans actually differ. That needs four scans' worth of history for every row before column 0 contributes anything other than zero.

The stimulus therefore runs twelve complete scans over all 64 rows. Each value carries a term that depends on its scan, so a wrong delay depth shows up as a wrong mean.

On top of that, the stimulus adds random spikes, rows of equal values that test tie handling in the median, rejection constants that change between scans, idle cycles, and column tags that are out of range.

// File: rtl/colavg_pkg.sv
package colavg_pkg;
  localparam int NCOL = 5;
  localparam int NDLY = NCOL - 1;

  typedef struct packed {
    logic [NDLY-1:0] shiftEn;
    logic            finish;
  } colStrobe_t;
endpackage

// File: rtl/colavg_ctrl.sv
module colavg_ctrl
  import colavg_pkg::*;
(
  input  logic       inValid,
  input  logic [2:0] inCol,
  output colStrobe_t strobe
);
  always_comb begin
    for (int c = 0; c < NDLY; c++) begin
      strobe.shiftEn[c] = inValid && (inCol == 3'(c));
    end
    strobe.finish = inValid && (inCol == 3'(NDLY));
  end
endmodule

// File: rtl/colavg_delay.sv
module colavg_delay
  import colavg_pkg::*;
#(
  parameter int W    = 12,
  parameter int ROWS = 64,
  parameter int RW   = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  colStrobe_t               strobe,
  input  logic [RW-1:0]            inRow,
  input  logic [W-1:0]             inData,
  output logic [NCOL-1:0][W-1:0]   aligned
);
  genvar c;
  generate
    for (c = 0; c < NDLY; c++) begin : g_col
      localparam int D = NDLY - c;
      logic [W-1:0] line [ROWS][D];
      logic [W-1:0] hold;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          hold <= '0;
          for (int r = 0; r < ROWS; r++) begin
            for (int k = 0; k < D; k++) begin
              line[r][k] <= '0;
            end
          end
        end else if (strobe.shiftEn[c]) begin
          hold <= line[inRow][D-1];
          line[inRow][0] <= inData;
          for (int k = 1; k < D; k++) begin
            line[inRow][k] <= line[inRow][k-1];
          end
        end
      end

      assign aligned[c] = hold;
    end
  endgenerate

  assign aligned[NDLY] = inData;
endmodule

// File: rtl/colavg_reduce.sv
module colavg_reduce
  import colavg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [NCOL-1:0][W-1:0] vals,
  input  logic [W-1:0]           rejK,
  output logic [W-1:0]           avg,
  output logic [2:0]             cnt
);
  localparam int F  = W + 6;
  localparam int SW = W + 3;
  localparam int PW = SW + F + 1;

  function automatic logic [F:0] recipOf(input logic [2:0] n);
    case (n)
      3'd1:    recipOf = (F+1)'((64'd1 << F));
      3'd2:    recipOf = (F+1)'(((64'd1 << F) + 64'd1) / 64'd2);
      3'd3:    recipOf = (F+1)'(((64'd1 << F) + 64'd2) / 64'd3);
      3'd4:    recipOf = (F+1)'(((64'd1 << F) + 64'd3) / 64'd4);
      3'd5:    recipOf = (F+1)'(((64'd1 << F) + 64'd4) / 64'd5);
      default: recipOf = '0;
    endcase
  endfunction

  logic [2:0]    rank [NCOL];
  logic [W-1:0]  med;
  logic [W:0]    limit;
  logic [SW-1:0] sum;
  logic [F:0]    recip;
  logic [PW-1:0] prod;

  always_comb begin
    for (int i = 0; i < NCOL; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NCOL; j++) begin
        if (j != i && ((vals[j] < vals[i]) || (vals[j] == vals[i] && j < i))) begin
          rank[i] = rank[i] + 3'd1;
        end
      end
    end
  end

  always_comb begin
    med = '0;
    for (int i = 0; i < NCOL; i++) begin
      if (rank[i] == 3'(NCOL / 2)) med = vals[i];
    end
  end

  always_comb begin
    limit = {1'b0, med} + {1'b0, rejK};
    sum   = '0;
    cnt   = '0;
    for (int i = 0; i < NCOL; i++) begin
      if ({1'b0, vals[i]} <= limit) begin
        sum = sum + SW'(vals[i]);
        cnt = cnt + 3'd1;
      end
    end
    recip = recipOf(cnt);
    prod  = PW'(sum) * PW'(recip) + (PW'(1) << (F - 1));
    avg   = prod[F +: W];
  end
endmodule

// File: rtl/colavg_top.sv
module colavg_top
  import colavg_pkg::*;
#(
  parameter int W    = 12,
  parameter int ROWS = 64,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [2:0]    inCol,
  input  logic [RW-1:0] inRow,
  input  logic [W-1:0]  inData,
  input  logic [W-1:0]  rejectK,
  output logic          outValid,
  output logic [RW-1:0] outRow,
  output logic [W-1:0]  outAvg,
  output logic [2:0]    outCount
);
  colStrobe_t              strobe;
  logic [NCOL-1:0][W-1:0]  aligned;
  logic [W-1:0]            avgNext;
  logic [2:0]              cntNext;

  colavg_ctrl u_ctrl (
    .inValid(inValid),
    .inCol  (inCol),
    .strobe (strobe)
  );

  colavg_delay #(.W(W), .ROWS(ROWS), .RW(RW)) u_delay (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inRow  (inRow),
    .inData (inData),
    .aligned(aligned)
  );

  colavg_reduce #(.W(W)) u_reduce (
    .vals(aligned),
    .rejK(rejectK),
    .avg (avgNext),
    .cnt (cntNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRow   <= '0;
      outAvg   <= '0;
      outCount <= '0;
    end else begin
      outValid <= strobe.finish;
      if (strobe.finish) begin
        outRow   <= inRow;
        outAvg   <= avgNext;
        outCount <= cntNext;
      end
    end
  end
endmodule

// File: rtl/colavg_chk.sv
module colavg_chk #(
  parameter int RW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic [2:0]    inCol,
  input logic [RW-1:0] inRow,
  input logic          outValid,
  input logic [RW-1:0] outRow,
  input logic [2:0]    outCount
);
  p_result_after_close_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inCol == 3'd4) |=> outValid);

  p_row_echo_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inCol == 3'd4) |=> (outRow == $past(inRow)));

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inCol == 3'd4) |=> !outValid);

  p_count_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCount >= 3'd1 && outCount <= 3'd5));
endmodule

bind colavg_top colavg_chk #(.RW(RW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inCol   (inCol),
  .inRow   (inRow),
  .outValid(outValid),
  .outRow  (outRow),
  .outCount(outCount)
);

// File: tb/tb_colavg_top.sv
module tb_colavg_top;
  localparam int W     = 12;
  localparam int ROWS  = 64;
  localparam int RW    = $clog2(ROWS);
  localparam int NSCAN = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [2:0]    inCol = '0;
  logic [RW-1:0] inRow = '0;
  logic [W-1:0]  inData = '0;
  logic [W-1:0]  rejectK = '0;
  logic          outValid;
  logic [RW-1:0] outRow;
  logic [W-1:0]  outAvg;
  logic [2:0]    outCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int dat [NSCAN][ROWS][5];
  int baseOf [ROWS];
  bit pendValid = 0;
  int pendRow, pendAvg, pendCnt, pendScan;

  always #10 clk = ~clk;

  colavg_top #(.W(W), .ROWS(ROWS)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCol(inCol), .inRow(inRow),
    .inData(inData), .rejectK(rejectK), .outValid(outValid), .outRow(outRow),
    .outAvg(outAvg), .outCount(outCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare outputs with what the previous cycle's input implies
  task automatic compareNow();
    if (pendValid) begin
      check(outValid == 1'b1, "R2 outValid", int'(outValid), 1);
      check(int'(outRow) == pendRow, "R2 outRow", int'(outRow), pendRow);
      check(int'(outCount) == pendCnt, "R4 outCount", int'(outCount), pendCnt);
      check(outCount >= 3'd1, "R5 count nonzero", int'(outCount), 1);
      if (pendScan < 4)
        check(int'(outAvg) == pendAvg, "R9/R6 early-scan avg", int'(outAvg), pendAvg);
      else
        check(int'(outAvg) == pendAvg, "R3/R6 aligned avg", int'(outAvg), pendAvg);
    end else begin
      check(outValid == 1'b0, "R8 no output", int'(outValid), 0);
    end
  endtask

  // reference: median, rejection, rounded mean
  task automatic expectFor(input int s, input int r, input int k);
    int a[5];
    int srt[5];
    int med, n, sum, t;
    for (int c = 0; c < 5; c++) begin
      a[c] = (s - (4 - c) >= 0) ? dat[s - 4 + c][r][c] : 0;
      srt[c] = a[c];
    end
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 4 - i; j++)
        if (srt[j] > srt[j+1]) begin t = srt[j]; srt[j] = srt[j+1]; srt[j+1] = t; end
    med = srt[2];
    n = 0; sum = 0;
    for (int c = 0; c < 5; c++)
      if (a[c] <= med + k) begin n++; sum += a[c]; end
    pendRow = r; pendCnt = n; pendScan = s;
    pendAvg = (2 * sum + n) / (2 * n);
  endtask

  task automatic cycle(input bit v, input int col, input int row, input int d, input int k, input bit last, input int s);
    @(negedge clk);
    compareNow();
    inValid = v; inCol = 3'(col); inRow = RW'(row); inData = W'(d); rejectK = W'(k);
    pendValid = last;
    if (last) expectFor(s, row, k);
  endtask

  function automatic int kForScan(input int s);
    case (s % 4)
      0: return 4095;
      1: return 0;
      2: return 25;
      default: return 300;
    endcase
  endfunction

  initial begin
    for (int r = 0; r < ROWS; r++) baseOf[r] = $urandom_range(100, 2500);
    for (int s = 0; s < NSCAN; s++)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < 5; c++) begin
          int v;
          if (r % 8 == 0) v = baseOf[r];                       // ties in the median
          else begin
            v = baseOf[r] + 40 * ((s + c) % 5) + $urandom_range(0, 31);
            if ($urandom_range(0, 5) == 0) v += $urandom_range(200, 1200);  // hit
          end
          if (v > 4095) v = 4095;
          dat[s][r][c] = v;
        end

    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && outAvg == '0 && outCount == '0 && outRow == '0,
          "R1 reset outputs", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && outAvg == '0, "R1 after release", int'(outAvg), 0);

    for (int s = 0; s < NSCAN; s++) begin
      int k;
      k = kForScan(s);   // R7: constant changes only between scans
      for (int r = 0; r < ROWS; r++) begin
        // R10: columns 0..3 in a rotating order, column 4 last
        for (int i = 0; i < 4; i++) begin
          int c;
          c = (i + r + s) % 4;
          cycle(1'b1, c, r, dat[s][r][c], k, 1'b0, s);
          if ($urandom_range(0, 7) == 0) cycle(1'b0, 4, r, 4095, 0, 1'b0, s);        // R8 idle
          if ($urandom_range(0, 9) == 0) cycle(1'b1, 5 + (r % 3), r, 4095, 0, 1'b0, s); // R8 bad tag
        end
        cycle(1'b1, 4, r, dat[s][r][4], k, 1'b1, s);
      end
    end
    cycle(1'b0, 0, 0, 0, 0, 1'b0, 0);
    cycle(1'b0, 0, 0, 0, 0, 1'b0, 0);
    @(negedge clk);
    compareNow();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule